// File: doc/BRIEF.md
# Per-CPU Interrupt Level Controller

This block combines three kinds of interrupt request into a single 4-bit processor interrupt level for each CPU. The kinds are software interrupts raised by writes to a per-CPU register, a level-sensitive local timer input for each CPU, and device interrupt lines shared across the system. Each CPU owns a 32-bit pending word. The software interrupts sit in its upper half and move down sixteen places to become level requests. The hardware bits in the lower half request their own bit index as a level.

The device lines pass through a shared master mask that also has a global disable bit. Each device line that survives the mask is translated to one level by a fixed bit-to-level rule, and the result goes to every CPU. Each CPU's output is the highest level requested, held in a register.

Software drives a per-CPU request port. It selects a CPU, an offset, and an operation: read the pending word, set software bits, or clear software bits. A separate port writes the master mask.

Top module: `cpu_irq_level_ctrl`

## Requirements
- R1: On reset, every pending word is 0, every output level is 0 and the master mask is 0x8000_0000, with bit 31 meaning global disable.
- R2: A CPU-port write at offset 2 ORs (wdata AND 0xFFFE_0000) into the pending word of the selected CPU only. Other CPUs are unchanged.
- R3: A CPU-port write at offset 1 clears each pending bit for which (wdata AND 0xFFFE_0000) is 1. When wdata bit 14 is 1, bit 31 is also cleared.
- R4: A CPU-port read at offset 0 returns the selected CPU's pending word, and a read at any other offset returns 0. Writes at offsets 0 and 3 change nothing.
- R5: Pending software bit 16+n (n = 1..15) requests level n. Pending bit n in 15:1 requests level n.
- R6: Pending bit 14 of CPU i follows that CPU's timer input one clock later. It requests level 14 while it is high, and software clears never affect it.
- R7: Device line j requests level 1 + (j mod 15) only when all of these hold: master-mask bit 31 is 0, master-mask bit j is 0, and j is a bit set in 0x705D_FF80. All other lines are ignored.
- R8: A master-port write at offset 2 sets mask bits and a write at offset 1 clears them, both using wdata. Only bits in 0xF05D_FF80 are stored and the rest read 0. Offsets 0 and 3 are ignored.
- R9: Each CPU's output level is the highest requested level in 1..15, or 0 when none is requested. It is registered one clock after the pending word and device lines it depends on.
- R10: A device request reaches the level of every CPU at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | CPU-port request strobe |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_sel | input | CPU_IDX_W | Target CPU index |
| cpu_req_offs | input | 2 | 0 = pending, 1 = clear soft, 2 = set soft |
| cpu_req_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, combinational |
| gbl_wr_valid | input | 1 | Master-mask write strobe |
| gbl_wr_offs | input | 2 | 1 = clear mask bits, 2 = set mask bits |
| gbl_wr_data | input | 32 | Master-mask write data |
| gbl_mask | output | 32 | Current master mask |
| dev_irq | input | 32 | Device interrupt lines, level-sensitive |
| cpu_timer | input | NUM_CPU | Per-CPU timer request, level-sensitive |
| cpu_level | output | 4*NUM_CPU | Level of CPU i in bits 4i+3:4i |

## Verification
The assertions assume a few things about the inputs:
- Reset is low at time zero and held for several clocks.
- Requests are sampled only on clock edges.
- At most one CPU-port write occurs per cycle, and the selected index names an existing CPU.

The bench stays within these limits. It drives every input at the falling edge, issues writes one at a time, and uses only CPU indices below the parameter. Device and timer lines are changed only between writes, so each expected level has one cause per step.

// File: rtl/cilc_pkg.sv
// Package: shared constants and pure functions of the interrupt level controller.
// Assumes a 32-bit pending word and a 4-bit level (levels 1..15).
package cilc_pkg;
    localparam int          WORD_W     = 32;
    localparam int          LEVEL_W    = 4;
    localparam int          VEC_W      = 16;
    localparam int          NUM_LEVELS = 15;
    localparam int          SOFT_SHIFT = 16;
    localparam int          TIMER_POS  = 14;
    localparam int          ALIAS_POS  = 14;
    localparam int          DIS_POS    = 31;
    localparam logic [31:0] SOFT_MASK  = 32'hFFFE_0000;
    localparam logic [31:0] HARD_MASK  = 32'h0000_FFFE;
    localparam logic [31:0] DEV_OK     = 32'h705D_FF80;
    localparam logic [31:0] MASK_KEEP  = DEV_OK | (32'h1 << DIS_POS);

    typedef enum logic [1:0] {
        OFF_PEND = 2'd0,
        OFF_CLR  = 2'd1,
        OFF_SET  = 2'd2,
        OFF_RSVD = 2'd3
    } offs_e;

    // Level requested by device line j.
    function automatic logic [LEVEL_W-1:0] dev_level(input int j);
        return LEVEL_W'(1 + (j % NUM_LEVELS));
    endfunction

    // Highest set index in v[15:1]; 0 when none is set.
    function automatic logic [LEVEL_W-1:0] top_level(input logic [VEC_W-1:0] v);
        logic [LEVEL_W-1:0] lv;
        lv = '0;
        for (int j = 1; j < VEC_W; j++) begin
            if (v[j]) lv = LEVEL_W'(j);
        end
        return lv;
    endfunction
endpackage

// File: rtl/cilc_master_gate.sv
// Module: master mask register and device-line gate.
// Holds the shared mask. Bit 31 is the global disable. Turns the surviving
// device lines into a 16-bit level request vector that all CPUs share.
// Assumes device lines are synchronous to clk.
module cilc_master_gate
    import cilc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [1:0]          wr_offs,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [WORD_W-1:0]   dev_irq,
    output logic [WORD_W-1:0]   mask_q,
    output logic [VEC_W-1:0]    dev_vec
);
    logic [WORD_W-1:0] live;

    // Mask register: the set and clear writes touch only the stored bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 32'h1 << DIS_POS;
        end else if (wr_valid && wr_offs == OFF_SET) begin
            mask_q <= (mask_q | wr_data) & MASK_KEEP;
        end else if (wr_valid && wr_offs == OFF_CLR) begin
            mask_q <= (mask_q & ~wr_data) & MASK_KEEP;
        end
    end

    // Live device lines: maskable, unmasked, and not globally disabled.
    always_comb begin
        live = mask_q[DIS_POS] ? '0 : (dev_irq & DEV_OK & ~mask_q);
    end

    // Translate each live line to its level bit.
    always_comb begin
        dev_vec = '0;
        for (int j = 0; j < WORD_W; j++) begin
            if (live[j]) dev_vec[dev_level(j)] = 1'b1;
        end
    end
endmodule

// File: rtl/cilc_cpu_pending.sv
// Module: pending word of one CPU.
// Software bits 31:17 are set and cleared by register writes. Bit 14 tracks
// the timer input. All other bits stay 0.
// Assumes set and clear never arrive in the same cycle.
module cilc_cpu_pending
    import cilc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                do_set,
    input  logic                do_clr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                timer,
    output logic [WORD_W-1:0]   pend_q
);
    logic [WORD_W-1:0] clr_bits;
    logic [WORD_W-1:0] soft_nxt;

    // Clear pattern: bit 14 in the data also selects soft level 15.
    always_comb begin
        clr_bits = wdata;
        if (wdata[ALIAS_POS]) clr_bits[DIS_POS] = 1'b1;
        clr_bits = clr_bits & SOFT_MASK;
    end

    // Next software field after this cycle's write.
    always_comb begin
        soft_nxt = pend_q & SOFT_MASK;
        if (do_clr) soft_nxt = soft_nxt & ~clr_bits;
        if (do_set) soft_nxt = soft_nxt | (wdata & SOFT_MASK);
    end

    // Pending register: software field plus the sampled timer bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q            <= soft_nxt;
            pend_q[TIMER_POS] <= timer;
        end
    end
endmodule

// File: rtl/cilc_level_enc.sv
// Module: level vector builder and registered priority encoder for one CPU.
// Shifts the software field down, ORs the hardware bits and the shared device
// vector, then registers the highest requested level.
module cilc_level_enc
    import cilc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    pend,
    input  logic [VEC_W-1:0]     dev_vec,
    output logic [LEVEL_W-1:0]   level_q
);
    logic [WORD_W-1:0] soft_dn;
    logic [VEC_W-1:0]  vec;

    // Merge the three request sources into one level vector.
    always_comb begin
        soft_dn = (pend & SOFT_MASK) >> SOFT_SHIFT;
        vec     = soft_dn[VEC_W-1:0] | (pend[VEC_W-1:0] & HARD_MASK[VEC_W-1:0]) | dev_vec;
    end

    // Output register: highest requested level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= top_level(vec);
    end
endmodule

// File: rtl/cpu_irq_level_ctrl.sv
// Module: top of the per-CPU interrupt level controller.
// Decodes the CPU request port, builds one pending word and one level encoder
// per CPU, and shares one master gate. Assumes NUM_CPU >= 2.
module cpu_irq_level_ctrl
    import cilc_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    localparam int CPU_IDX_W = $clog2(NUM_CPU)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req_valid,
    input  logic                         cpu_req_write,
    input  logic [CPU_IDX_W-1:0]         cpu_req_sel,
    input  logic [1:0]                   cpu_req_offs,
    input  logic [31:0]                  cpu_req_wdata,
    output logic [31:0]                  cpu_rdata,
    input  logic                         gbl_wr_valid,
    input  logic [1:0]                   gbl_wr_offs,
    input  logic [31:0]                  gbl_wr_data,
    output logic [31:0]                  gbl_mask,
    input  logic [31:0]                  dev_irq,
    input  logic [NUM_CPU-1:0]           cpu_timer,
    output logic [NUM_CPU*LEVEL_W-1:0]   cpu_level
);
    logic [VEC_W-1:0]          dev_vec;
    logic [NUM_CPU*WORD_W-1:0] pend_flat;
    logic                      wr_set;
    logic                      wr_clr;

    // Request decode: the write kinds, independent of the CPU selected.
    always_comb begin
        wr_set = cpu_req_valid && cpu_req_write && cpu_req_offs == OFF_SET;
        wr_clr = cpu_req_valid && cpu_req_write && cpu_req_offs == OFF_CLR;
    end

    cilc_master_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (gbl_wr_valid),
        .wr_offs  (gbl_wr_offs),
        .wr_data  (gbl_wr_data),
        .dev_irq  (dev_irq),
        .mask_q   (gbl_mask),
        .dev_vec  (dev_vec)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        logic hit;
        assign hit = cpu_req_sel == CPU_IDX_W'(i);

        cilc_cpu_pending u_pend (
            .clk    (clk),
            .rst_n  (rst_n),
            .do_set (wr_set && hit),
            .do_clr (wr_clr && hit),
            .wdata  (cpu_req_wdata),
            .timer  (cpu_timer[i]),
            .pend_q (pend_flat[i*WORD_W +: WORD_W])
        );

        cilc_level_enc u_enc (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend    (pend_flat[i*WORD_W +: WORD_W]),
            .dev_vec (dev_vec),
            .level_q (cpu_level[i*LEVEL_W +: LEVEL_W])
        );
    end

    // Read mux: the pending word at offset 0, otherwise zero.
    always_comb begin
        cpu_rdata = '0;
        if (cpu_req_valid && !cpu_req_write && cpu_req_offs == OFF_PEND) begin
            for (int i = 0; i < NUM_CPU; i++) begin
                if (cpu_req_sel == CPU_IDX_W'(i)) cpu_rdata = pend_flat[i*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/cilc_checker.sv
// Module: assertion checker for cpu_irq_level_ctrl, attached by bind.
// Assumes reset is low at time zero and at most one CPU write per cycle.
module cilc_checker
    import cilc_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    localparam int CPU_IDX_W = $clog2(NUM_CPU)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cpu_req_valid,
    input logic                         cpu_req_write,
    input logic [CPU_IDX_W-1:0]         cpu_req_sel,
    input logic [1:0]                   cpu_req_offs,
    input logic [31:0]                  cpu_req_wdata,
    input logic [31:0]                  gbl_mask,
    input logic [NUM_CPU-1:0]           cpu_timer,
    input logic [NUM_CPU*WORD_W-1:0]    pend_flat,
    input logic [NUM_CPU*LEVEL_W-1:0]   cpu_level
);
    // R1: first cycle after reset shows the reset state.
    p_reset_state_r1: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (gbl_mask == 32'h8000_0000 && cpu_level == '0));

    // R2: a set write leaves its soft bits pending in the selected CPU.
    p_soft_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_write && cpu_req_offs == 2'd2) |=>
        ((pend_flat[$past(cpu_req_sel)*WORD_W +: WORD_W] & $past(cpu_req_wdata) & SOFT_MASK)
            == ($past(cpu_req_wdata) & SOFT_MASK)));

    // R3: a clear write with bit 14 set removes soft level 15.
    p_alias_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_write && cpu_req_offs == 2'd1 && cpu_req_wdata[14]) |=>
        !pend_flat[$past(cpu_req_sel)*WORD_W + 31]);

    // R8: only the stored mask bits can be 1.
    p_mask_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gbl_mask & ~MASK_KEEP) == '0);

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_chk
        // R6: pending bit 14 follows the timer one clock later.
        p_timer_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> pend_flat[i*WORD_W + TIMER_POS] == $past(cpu_timer[i]));

        // R5: pending soft level 15 gives output level 15 one clock later.
        p_soft15_r5: assert property (@(posedge clk) disable iff (!rst_n)
            pend_flat[i*WORD_W + 31] |=> cpu_level[i*LEVEL_W +: LEVEL_W] == 4'd15);

        // R7: with the system disabled and nothing pending, the level drops to 0.
        p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (gbl_mask[31] && pend_flat[i*WORD_W +: WORD_W] == '0) |=>
            cpu_level[i*LEVEL_W +: LEVEL_W] == 4'd0);
    end
endmodule

bind cpu_irq_level_ctrl cilc_checker #(.NUM_CPU(NUM_CPU)) u_cilc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_sel   (cpu_req_sel),
    .cpu_req_offs  (cpu_req_offs),
    .cpu_req_wdata (cpu_req_wdata),
    .gbl_mask      (gbl_mask),
    .cpu_timer     (cpu_timer),
    .pend_flat     (pend_flat),
    .cpu_level     (cpu_level)
);

// File: tb/cpu_irq_level_ctrl_test.sv
module cpu_irq_level_ctrl_test;
    localparam int N  = 4;
    localparam int IW = $clog2(N);
    localparam logic [31:0] SOFT = 32'hFFFE_0000;
    localparam logic [31:0] DOK  = 32'h705D_FF80;
    localparam logic [31:0] KEEP = 32'hF05D_FF80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [IW-1:0] cpu_req_sel = '0;
    logic [1:0] cpu_req_offs = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic [31:0] cpu_rdata;
    logic gbl_wr_valid = 1'b0;
    logic [1:0] gbl_wr_offs = '0;
    logic [31:0] gbl_wr_data = '0;
    logic [31:0] gbl_mask;
    logic [31:0] dev_irq = '0;
    logic [N-1:0] cpu_timer = '0;
    logic [N*4-1:0] cpu_level;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_pend [N];
    logic [31:0] m_mask;

    always #5 clk = ~clk;

    cpu_irq_level_ctrl #(.NUM_CPU(N)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected level from the model, following R5, R7, R9.
    function automatic logic [3:0] exp_level(input int i);
        logic [15:0] v;
        logic [31:0] s;
        logic [3:0]  lv;
        s = (m_pend[i] & SOFT) >> 16;
        v = s[15:0] | (m_pend[i][15:0] & 16'hFFFE);
        if (!m_mask[31]) begin
            for (int j = 0; j < 32; j++)
                if (dev_irq[j] && !m_mask[j] && DOK[j]) v[1 + (j % 15)] = 1'b1;
        end
        lv = 4'd0;
        for (int k = 1; k < 16; k++) if (v[k]) lv = 4'(k);
        return lv;
    endfunction

    task automatic cpu_wr(input int sel, input logic [1:0] offs, input logic [31:0] d);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1;
        cpu_req_sel = IW'(sel); cpu_req_offs = offs; cpu_req_wdata = d;
        @(negedge clk);
        cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
    endtask

    task automatic gbl_wr(input logic [1:0] offs, input logic [31:0] d);
        @(negedge clk);
        gbl_wr_valid = 1'b1; gbl_wr_offs = offs; gbl_wr_data = d;
        @(negedge clk);
        gbl_wr_valid = 1'b0;
    endtask

    task automatic cpu_rd(input int sel, input logic [1:0] offs, output logic [31:0] d);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0;
        cpu_req_sel = IW'(sel); cpu_req_offs = offs;
        #1 d = cpu_rdata;
        cpu_req_valid = 1'b0;
    endtask

    // Wait long enough for pending and level registers, then compare all CPUs.
    task automatic check_all(input string tag);
        logic [31:0] d;
        repeat (3) @(negedge clk);
        chk({tag, " mask"}, gbl_mask, m_mask);
        for (int i = 0; i < N; i++) begin
            cpu_rd(i, 2'd0, d);
            chk($sformatf("%s pend cpu%0d", tag, i), d, m_pend[i]);
            chk($sformatf("%s level cpu%0d", tag, i), 32'(cpu_level[i*4 +: 4]), 32'(exp_level(i)));
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < N; i++) m_pend[i] = '0;
        m_mask = 32'h8000_0000;
        check_all("R1 reset");
    endtask

    task automatic t_soft_set;
        cpu_wr(1, 2'd2, 32'hFFFF_FFFF);
        m_pend[1] = SOFT;
        check_all("R2 R5 set all on cpu1");
        cpu_wr(2, 2'd2, 32'h0004_FFFF);
        m_pend[2] = 32'h0004_0000;
        check_all("R2 R5 set level2 cpu2");
    endtask

    task automatic t_soft_clear;
        cpu_wr(1, 2'd1, 32'h4000_0000);
        m_pend[1] = m_pend[1] & ~32'h4000_0000;
        check_all("R3 clear bit30 keeps 31");
        cpu_wr(1, 2'd1, 32'h0000_4000);
        m_pend[1] = m_pend[1] & ~32'h8000_0000;
        check_all("R3 alias clears level15");
        cpu_wr(1, 2'd1, 32'h7FFE_0000);
        m_pend[1] = '0;
        check_all("R3 clear rest");
    endtask

    task automatic t_offsets;
        logic [31:0] d;
        cpu_wr(3, 2'd0, 32'hFFFF_FFFF);
        cpu_wr(3, 2'd3, 32'hFFFF_FFFF);
        check_all("R4 offsets 0 and 3 ignored");
        cpu_rd(2, 2'd1, d);
        chk("R4 read offset1 zero", d, 32'h0);
        cpu_rd(2, 2'd3, d);
        chk("R4 read offset3 zero", d, 32'h0);
    endtask

    task automatic t_timer;
        @(negedge clk) cpu_timer[2] = 1'b1;
        m_pend[2][14] = 1'b1;
        check_all("R6 timer high level14");
        cpu_wr(2, 2'd1, 32'hFFFF_FFFF);
        m_pend[2] = m_pend[2] & ~SOFT;
        check_all("R6 soft clear keeps timer bit");
        @(negedge clk) cpu_timer[2] = 1'b0;
        m_pend[2][14] = 1'b0;
        check_all("R6 timer low");
    endtask

    task automatic t_mask;
        gbl_wr(2'd2, 32'hFFFF_FFFF);
        m_mask = KEEP;
        check_all("R8 set all mask bits");
        gbl_wr(2'd0, 32'h0);
        gbl_wr(2'd3, 32'h0);
        check_all("R8 offsets 0 and 3 ignored");
        gbl_wr(2'd1, 32'hFFFF_FFFF);
        m_mask = '0;
        check_all("R8 clear all mask bits");
    endtask

    task automatic t_devices;
        @(negedge clk) dev_irq = 32'h0000_0080;
        check_all("R7 R10 line7 level8 all cpus");
        @(negedge clk) dev_irq = 32'h0000_0001;
        check_all("R7 unmaskable line ignored");
        @(negedge clk) dev_irq = 32'h2000_0080;
        check_all("R7 line29 level15");
        gbl_wr(2'd2, 32'h2000_0000);
        m_mask = 32'h2000_0000;
        check_all("R7 line29 masked");
        gbl_wr(2'd2, 32'h8000_0000);
        m_mask = 32'hA000_0000;
        check_all("R7 global disable");
        gbl_wr(2'd1, 32'hFFFF_FFFF);
        m_mask = '0;
    endtask

    task automatic t_priority;
        @(negedge clk) dev_irq = 32'h0001_0000;
        cpu_wr(0, 2'd2, 32'h0008_0000);
        m_pend[0] = 32'h0008_0000;
        check_all("R9 soft3 vs dev2");
        @(negedge clk) cpu_timer[3] = 1'b1;
        m_pend[3][14] = 1'b1;
        cpu_wr(3, 2'd2, 32'h8000_0000);
        m_pend[3] = m_pend[3] | 32'h8000_0000;
        check_all("R9 soft15 over timer14");
        @(negedge clk) begin dev_irq = '0; cpu_timer = '0; end
        m_pend[3][14] = 1'b0;
        check_all("R9 sources removed");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_soft_set();
        t_soft_clear();
        t_offsets();
        t_timer();
        t_mask();
        t_devices();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule